// File: doc/BRIEF.md
# PWM Fault Input Conditioner

This block sits between eight external fault pins and a PWM controller's output override logic. Each pin passes through a two-flop synchronizer. An optional glitch filter follows, and then a polarity compare that turns the pin level into a fault condition. A small per-input state machine turns that condition into a fault-active flag. The flag follows the condition directly, or it latches until software acknowledges it. The OR of all flags is registered and drives the combined fault signal that the PWM outputs use to enter their safe state.

Three configuration fields are packed into one 32-bit register, each with one bit per input: active level, filter enable and latch mode. Either of two write-protect inputs blocks writes to this register. A separate clear register supplies a vector of one-cycle acknowledge strobes, one per input.

Each per-input state machine has four states. FS_IDLE means no fault. FS_ACTIVE is a non-latched fault that returns to FS_IDLE when the condition goes away. FS_HELD is a latched fault waiting for an acknowledge. FS_ARMED is a latched fault that has been acknowledged while the condition was still present, and it returns to FS_IDLE when the condition goes away. From FS_IDLE the condition leads to FS_ACTIVE when the mode bit is 0, or to FS_HELD when it is 1. From FS_HELD a clear strobe leads to FS_IDLE if the condition is absent, or to FS_ARMED if it is present. Otherwise the machine stays in FS_HELD.

Top module: `pwm_fault_cond`

## Requirements
- R1: While reset is asserted and on the first cycle after it, cfg_rdata reads 0 and all flags and flt_any are 0. This makes every input active-low, unfiltered and non-latched.
- R2: An unprotected write stores cfg_wdata[7:0] as active level, [15:8] as latch mode and [23:16] as filter enable. cfg_rdata returns these fields in the same places on the next cycle, and bits 31:24 always read 0.
- R3: A write issued while wprot_sw or wprot_hw is high leaves the register unchanged.
- R4: The active-level bit for input y selects which pin level is a fault: 0 makes a low level the fault, 1 makes a high level the fault.
- R5: With filtering off, a pin change driven before rising edge k shows on flt_active at edge k+2.
- R6: With filtering on, a pin pulse lasting 3 cycles or fewer never raises the flag. A level held for at least 4 synchronized cycles does raise it.
- R7: In non-latched mode the flag drops once the fault condition is gone, with no clear needed.
- R8: In latched mode the flag stays high after the condition is gone, until a clear strobe for that input arrives. It drops on the edge after that strobe.
- R9: A clear strobe that arrives while a latched condition is still present is kept pending. The flag then drops when the condition goes away, with no further strobe.
- R10: A clear strobe has no effect on a non-latched input. A strobe on an input without a fault leaves nothing pending.
- R11: flt_any equals the OR of flt_active one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| wprot_sw | input | 1 | Software write-protect status |
| wprot_hw | input | 1 | Hardware write-protect status |
| cfg_rdata | output | 32 | Configuration register contents |
| flt_in | input | 8 | Asynchronous fault pins |
| flt_clr | input | 8 | Per-input acknowledge strobes |
| flt_active | output | 8 | Per-input fault-active flags |
| flt_any | output | 1 | Registered OR of the flags |

## Verification
The hardest state to reach is FS_ARMED. To get there, a clear strobe must land while a latched condition is still present. That condition is itself delayed by the synchronizer and possibly the filter. The bench holds the pin in its fault level long enough for the flag to be seen high, pulses the clear strobe, and checks that the flag stays high. It then releases the pin and expects the flag to fall with no second strobe. A contrasting run strobes an idle input and then raises a latched fault, to show that the earlier strobe left nothing pending.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;

    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        FS_IDLE   = 2'd0,
        FS_ACTIVE = 2'd1,
        FS_HELD   = 2'd2,
        FS_ARMED  = 2'd3
    } fault_st_e;

endpackage

// File: rtl/pwm_fault_sync.sv
module pwm_fault_sync #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    // Stages reset high: the idle level of an active-low fault pin.
    logic [W-1:0] stage [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) stage[s] <= '1;
        end else begin
            stage[0] <= d_async;
            for (int s = 1; s < DEPTH; s++) stage[s] <= stage[s-1];
        end
    end

    assign q_sync = stage[DEPTH-1];
endmodule

// File: rtl/pwm_fault_filter.sv
module pwm_fault_filter #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic din,
    output logic dout
);
    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    logic          filt_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= 1'b1;
            cnt_q  <= '0;
        end else if (!en || din == filt_q) begin
            // Bypassed or stable: track the input and restart the count.
            filt_q <= din;
            cnt_q  <= '0;
        end else if (cnt_q == LAST) begin
            filt_q <= din;
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign dout = en ? filt_q : din;
endmodule

// File: rtl/pwm_fault_chan.sv
module pwm_fault_chan
    import pwm_fault_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic latch_mode,
    input  logic clr,
    output logic active
);
    fault_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FS_IDLE:   if (cond) st_d = latch_mode ? FS_HELD : FS_ACTIVE;
            FS_ACTIVE: if (!cond) st_d = FS_IDLE;
            FS_HELD:   if (clr) st_d = cond ? FS_ARMED : FS_IDLE;
            FS_ARMED:  if (!cond) st_d = FS_IDLE;
            default:   st_d = FS_IDLE;
        endcase
    end

    always_comb begin
        unique case (st_q)
            FS_IDLE: active = 1'b0;
            default: active = 1'b1;
        endcase
    end
endmodule

// File: rtl/pwm_fault_cfg.sv
module pwm_fault_cfg
    import pwm_fault_pkg::*;
#(
    parameter int N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3*N-1:0]   wdata,
    input  logic             prot_a,
    input  logic             prot_b,
    output logic [N-1:0]     lvl,
    output logic [N-1:0]     latch,
    output logic [N-1:0]     filt,
    output logic [REG_W-1:0] rdata
);
    logic wr_ok;
    assign wr_ok = wr_en && !prot_a && !prot_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl   <= '0;
            latch <= '0;
            filt  <= '0;
        end else if (wr_ok) begin
            lvl   <= wdata[N-1:0];
            latch <= wdata[2*N-1:N];
            filt  <= wdata[3*N-1:2*N];
        end
    end

    assign rdata = REG_W'({filt, latch, lvl});
endmodule

// File: rtl/pwm_fault_cond.sv
module pwm_fault_cond
    import pwm_fault_pkg::*;
#(
    parameter int N_FLT     = 8,
    parameter int SYNC_DEPTH = 2,
    parameter int FILT_HOLD  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [31:0]      cfg_wdata,
    input  logic             wprot_sw,
    input  logic             wprot_hw,
    output logic [31:0]      cfg_rdata,
    input  logic [N_FLT-1:0] flt_in,
    input  logic [N_FLT-1:0] flt_clr,
    output logic [N_FLT-1:0] flt_active,
    output logic             flt_any
);
    localparam int FW = 3 * N_FLT;

    logic [N_FLT-1:0] lvl, latch, filt, pin_s, pin_q, cond;
    logic             unused_hi;

    assign unused_hi = ^cfg_wdata[REG_W-1:FW];

    pwm_fault_cfg #(.N(N_FLT)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wdata(cfg_wdata[FW-1:0]),
        .prot_a(wprot_sw), .prot_b(wprot_hw),
        .lvl(lvl), .latch(latch), .filt(filt), .rdata(cfg_rdata)
    );

    pwm_fault_sync #(.W(N_FLT), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(flt_in), .q_sync(pin_s)
    );

    for (genvar y = 0; y < N_FLT; y++) begin : g_ch
        pwm_fault_filter #(.HOLD(FILT_HOLD)) u_filt (
            .clk(clk), .rst_n(rst_n), .en(filt[y]), .din(pin_s[y]), .dout(pin_q[y])
        );
        assign cond[y] = (pin_q[y] == lvl[y]);
        pwm_fault_chan u_fsm (
            .clk(clk), .rst_n(rst_n), .cond(cond[y]), .latch_mode(latch[y]),
            .clr(flt_clr[y]), .active(flt_active[y])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_any <= 1'b0;
        else        flt_any <= |flt_active;
    end
endmodule

// File: rtl/pwm_fault_cond_chk.sv
module pwm_fault_cond_chk #(
    parameter int N_FLT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr_en,
    input logic [31:0]      cfg_wdata,
    input logic             wprot_sw,
    input logic             wprot_hw,
    input logic [31:0]      cfg_rdata,
    input logic [N_FLT-1:0] flt_active,
    input logic             flt_any
);
    localparam int FW = 3 * N_FLT;

    AST_RESET_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_rdata == 32'd0 && flt_any == 1'b0)); // R1
    AST_WRITE_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !wprot_sw && !wprot_hw) |=> cfg_rdata[FW-1:0] == $past(cfg_wdata[FW-1:0])); // R2
    AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[31:FW] == '0); // R2
    AST_WP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && (wprot_sw || wprot_hw)) |=> $stable(cfg_rdata)); // R3
    AST_ANY_OR: assert property (@(posedge clk) disable iff (!rst_n)
        flt_any == $past(|flt_active)); // R11
endmodule

bind pwm_fault_cond pwm_fault_cond_chk #(.N_FLT(N_FLT)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
    .wprot_sw(wprot_sw), .wprot_hw(wprot_hw), .cfg_rdata(cfg_rdata),
    .flt_active(flt_active), .flt_any(flt_any)
);

// File: tb/pwm_fault_cond_bench.sv
module pwm_fault_cond_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        wprot_sw = 1'b0;
    logic        wprot_hw = 1'b0;
    logic [31:0] cfg_rdata;
    logic [7:0]  flt_in = 8'hFF;
    logic [7:0]  flt_clr = '0;
    logic [7:0]  flt_active;
    logic        flt_any;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwm_fault_cond u_pwm_fault_cond (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
        .wprot_sw(wprot_sw), .wprot_hw(wprot_hw), .cfg_rdata(cfg_rdata),
        .flt_in(flt_in), .flt_clr(flt_clr), .flt_active(flt_active), .flt_any(flt_any)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] v);
        cfg_wr_en = 1'b1; cfg_wdata = v;
        tick(1);
        cfg_wr_en = 1'b0;
    endtask

    task automatic pulse_clr(input int y);
        flt_clr[y] = 1'b1;
        tick(1);
        flt_clr[y] = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 rdata in reset", cfg_rdata, 32'h0);
        check("R1 flags in reset", {23'h0, flt_any, flt_active}, 32'h0);
        rst_n = 1'b1;
        tick(1);
        check("R1 rdata after reset", cfg_rdata, 32'h0);
        tick(3);
        check("R1 flags after reset", {23'h0, flt_any, flt_active}, 32'h0);
    endtask

    task automatic t_regs;
        write_cfg(32'hFF12_3400);
        check("R2 readback", cfg_rdata, 32'h0012_3400);
        wprot_sw = 1'b1; write_cfg(32'h0000_0055); wprot_sw = 1'b0;
        check("R3 sw protect", cfg_rdata, 32'h0012_3400);
        wprot_hw = 1'b1; write_cfg(32'h0000_00AA); wprot_hw = 1'b0;
        check("R3 hw protect", cfg_rdata, 32'h0012_3400);
        write_cfg(32'h0);
        check("R2 cleared", cfg_rdata, 32'h0);
    endtask

    task automatic t_latency;
        flt_in[0] = 1'b0;
        tick(2);
        check("R5 not yet", {31'h0, flt_active[0]}, 32'h0);
        tick(1);
        check("R5 at edge k+2", {31'h0, flt_active[0]}, 32'h1);
        check("R11 any lags", {31'h0, flt_any}, 32'h0);
        tick(1);
        check("R11 any set", {31'h0, flt_any}, 32'h1);
        pulse_clr(0);
        tick(1);
        check("R10 mode0 clear ignored", {31'h0, flt_active[0]}, 32'h1);
        flt_in[0] = 1'b1;
        tick(4);
        check("R7 nonlatched drop", {31'h0, flt_active[0]}, 32'h0);
        tick(1);
        check("R11 any clear", {31'h0, flt_any}, 32'h0);
    endtask

    task automatic t_polarity;
        write_cfg(32'h0000_0002);
        tick(4);
        check("R4 high active", {31'h0, flt_active[1]}, 32'h1);
        flt_in[1] = 1'b0;
        tick(4);
        check("R4 low inactive", {31'h0, flt_active[1]}, 32'h0);
        write_cfg(32'h0);
        flt_in[1] = 1'b1;
        tick(4);
        check("R4 back to low active", {31'h0, flt_active[1]}, 32'h0);
    endtask

    task automatic t_latched;
        write_cfg(32'h0000_0400);
        flt_in[2] = 1'b0; tick(5);
        check("R8 latched set", {31'h0, flt_active[2]}, 32'h1);
        flt_in[2] = 1'b1; tick(6);
        check("R8 holds without clear", {31'h0, flt_active[2]}, 32'h1);
        pulse_clr(2);
        check("R8 drops after clear", {31'h0, flt_active[2]}, 32'h0);
        flt_in[2] = 1'b0; tick(5);
        pulse_clr(2); tick(3);
        check("R9 pending still high", {31'h0, flt_active[2]}, 32'h1);
        flt_in[2] = 1'b1; tick(4);
        check("R9 pending drops", {31'h0, flt_active[2]}, 32'h0);
        pulse_clr(2); tick(1);
        flt_in[2] = 1'b0; tick(5);
        flt_in[2] = 1'b1; tick(6);
        check("R10 idle clear not kept", {31'h0, flt_active[2]}, 32'h1);
        pulse_clr(2); tick(1);
        write_cfg(32'h0);
    endtask

    task automatic t_filter;
        int seen3 = 0;
        int seen4 = 0;
        write_cfg(32'h0008_0000);
        tick(2);
        flt_in[3] = 1'b0; flt_in[4] = 1'b0;
        tick(2);
        flt_in[4] = 1'b1;
        tick(1);
        flt_in[3] = 1'b1;
        for (int i = 0; i < 10; i++) begin
            tick(1);
            if (flt_active[3]) seen3++;
            if (flt_active[4]) seen4++;
        end
        check("R6 short pulse rejected", seen3, 0);
        check("R6 unfiltered pulse seen", {31'h0, seen4 > 0}, 32'h1);
        flt_in[3] = 1'b0; tick(10);
        check("R6 held level accepted", {31'h0, flt_active[3]}, 32'h1);
        flt_in[3] = 1'b1; tick(10);
        check("R6 filtered release", {31'h0, flt_active[3]}, 32'h0);
        write_cfg(32'h0);
    endtask

    initial begin
        tick(3);
        t_reset();
        t_regs();
        t_latency();
        t_polarity();
        t_latched();
        t_filter();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule